// File: doc/BRIEF.md
# Segmented DAC Code Sequencer

This block produces the digital control words for a three-segment audio converter. The converter has three analog parts. A coarse resistor string picks one pair of adjacent tap voltages. A time-sliced switch moves the output between the upper and lower tap of that pair. A pair of trim resistors at the two ends of the string shifts the whole string by a fraction of one tap. For every channel the block accepts an 18-bit two's-complement sample. It turns the sample into offset binary and splits it into a 9-bit tap code, a 3-bit switch code and a 6-bit trim code.

The block runs on the converter clock. A free-running slot counter defines a frame of 8 slots. A new sample is taken only at the end of a frame, so a switching pattern that has started always runs to its end. The upper-tap select goes high in the first slots of each frame, and the number of high slots equals the 3-bit code. The two trim outputs are complementary and always add up to 63. While reset is asserted, every channel shows the code for analog zero.

Top module: `sds_sequencer`

## Requirements
- R1: The input sample is two's complement. The code that drives the outputs is the sample with bit 17 inverted (offset binary), so input 0x00000 gives 0x20000, 0x1FFFF gives 0x3FFFF and 0x20000 gives 0x00000.
- R2: `tap_o` for a channel carries bits 17..9 of that channel's offset code.
- R3: Slots in a frame are numbered 0 to 7, and slot 0 is the cycle in which `frame_o` is high. In slot s, `pwm_hi_o` of a channel is 1 exactly when s is less than bits 8..6 of the offset code. A code of 0 therefore never selects the upper tap, and a code of 7 selects it in slots 0 to 6.
- R4: `trim_bot_o` carries bits 5..0 of the offset code.
- R5: `trim_top_o` equals 63 minus `trim_bot_o`, so the two trim codes always add up to 63.
- R6: A sample is captured on the clock edge that ends slot 7. Changes to `sample_i` at any other time have no effect on `tap_o`, `trim_top_o`, `trim_bot_o` or the switching pattern of the current frame.
- R7: A synchronous active-high `rst` sets every channel to offset code 0x20000. That gives tap 0x100, switch code 0, bottom trim 0 and top trim 63. It also puts the slot counter at slot 0, with `frame_o` high.
- R8: `frame_o` is high for one cycle out of every 8, and it marks slot 0.
- R9: Each channel decodes only its own slice of `sample_i`. Channel c uses bits 18c+17..18c, and its outputs are the c-th fields of the output buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | 36 | Two's-complement samples, channel c in bits 18c+17..18c |
| tap_o | output | 18 | 9-bit string tap code per channel |
| pwm_hi_o | output | 2 | Upper-tap select per channel |
| trim_top_o | output | 12 | 6-bit top trim code per channel |
| trim_bot_o | output | 12 | 6-bit bottom trim code per channel |
| frame_o | output | 1 | High in slot 0 of each frame |

## Verification
The bench builds the block with its default values: two channels and a 9/3/6 split of an 18-bit sample, which gives an 8-slot frame. These values put every switch code from 0 to 7 within reach of a single short frame. They also put the code extremes within reach: largest positive, most negative, zero and minus one. With two channels, the bench can drive different codes per channel and confirm that each decode stays independent. Random samples are changed part-way through a frame to show that nothing moves until the frame boundary.

// File: rtl/sds_pkg.sv
package sds_pkg;
  localparam int unsigned SDS_CHANNELS = 2;
  localparam int unsigned SDS_COARSE_W = 9;
  localparam int unsigned SDS_PWM_W    = 3;
  localparam int unsigned SDS_TRIM_W   = 6;
endpackage

// File: rtl/sds_slot_timer.sv
module sds_slot_timer #(
  parameter int unsigned PWM_W = sds_pkg::SDS_PWM_W
) (
  input  logic             clk,
  input  logic             rst,
  output logic             wrap_o,
  output logic [PWM_W-1:0] slot_nxt_o,
  output logic             frame_o
);
  localparam logic [PWM_W-1:0] LAST_SLOT = {PWM_W{1'b1}};

  logic [PWM_W-1:0] slot_q;

  assign wrap_o     = (slot_q == LAST_SLOT);
  assign slot_nxt_o = slot_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q  <= '0;
      frame_o <= 1'b1;
    end else begin
      slot_q  <= slot_nxt_o;
      frame_o <= (slot_nxt_o == '0);
    end
  end
endmodule

// File: rtl/sds_lane.sv
module sds_lane #(
  parameter int unsigned COARSE_W = sds_pkg::SDS_COARSE_W,
  parameter int unsigned PWM_W    = sds_pkg::SDS_PWM_W,
  parameter int unsigned TRIM_W   = sds_pkg::SDS_TRIM_W,
  localparam int unsigned DATA_W  = COARSE_W + PWM_W + TRIM_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_i,
  input  logic [PWM_W-1:0]    slot_nxt_i,
  input  logic [DATA_W-1:0]   sample_i,
  output logic [COARSE_W-1:0] tap_o,
  output logic                pwm_hi_o,
  output logic [TRIM_W-1:0]   trim_top_o,
  output logic [TRIM_W-1:0]   trim_bot_o
);
  localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [TRIM_W-1:0] TRIM_MAX = {TRIM_W{1'b1}};

  logic [DATA_W-1:0] code_q;
  logic [DATA_W-1:0] code_d;
  logic [DATA_W-1:0] offset_code;

  assign offset_code = {~sample_i[DATA_W-1], sample_i[DATA_W-2:0]};
  assign code_d      = load_i ? offset_code : code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q     <= MID_CODE;
      tap_o      <= MID_CODE[DATA_W-1 -: COARSE_W];
      pwm_hi_o   <= 1'b0;
      trim_bot_o <= '0;
      trim_top_o <= TRIM_MAX;
    end else begin
      code_q     <= code_d;
      tap_o      <= code_d[DATA_W-1 -: COARSE_W];
      pwm_hi_o   <= (slot_nxt_i < code_d[TRIM_W +: PWM_W]);
      trim_bot_o <= code_d[TRIM_W-1:0];
      trim_top_o <= TRIM_MAX - code_d[TRIM_W-1:0];
    end
  end
endmodule

// File: rtl/sds_sequencer.sv
module sds_sequencer #(
  parameter int unsigned CHANNELS = sds_pkg::SDS_CHANNELS,
  parameter int unsigned COARSE_W = sds_pkg::SDS_COARSE_W,
  parameter int unsigned PWM_W    = sds_pkg::SDS_PWM_W,
  parameter int unsigned TRIM_W   = sds_pkg::SDS_TRIM_W,
  localparam int unsigned DATA_W  = COARSE_W + PWM_W + TRIM_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [CHANNELS*DATA_W-1:0]   sample_i,
  output logic [CHANNELS*COARSE_W-1:0] tap_o,
  output logic [CHANNELS-1:0]          pwm_hi_o,
  output logic [CHANNELS*TRIM_W-1:0]   trim_top_o,
  output logic [CHANNELS*TRIM_W-1:0]   trim_bot_o,
  output logic                         frame_o
);
  logic             wrap;
  logic [PWM_W-1:0] slot_nxt;

  sds_slot_timer #(.PWM_W(PWM_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .wrap_o     (wrap),
    .slot_nxt_o (slot_nxt),
    .frame_o    (frame_o)
  );

  for (genvar c = 0; c < CHANNELS; c++) begin : g_lane
    sds_lane #(
      .COARSE_W (COARSE_W),
      .PWM_W    (PWM_W),
      .TRIM_W   (TRIM_W)
    ) u_lane (
      .clk        (clk),
      .rst        (rst),
      .load_i     (wrap),
      .slot_nxt_i (slot_nxt),
      .sample_i   (sample_i[c*DATA_W +: DATA_W]),
      .tap_o      (tap_o[c*COARSE_W +: COARSE_W]),
      .pwm_hi_o   (pwm_hi_o[c]),
      .trim_top_o (trim_top_o[c*TRIM_W +: TRIM_W]),
      .trim_bot_o (trim_bot_o[c*TRIM_W +: TRIM_W])
    );
  end
endmodule

// File: rtl/sds_checker.sv
module sds_checker #(
  parameter int unsigned CHANNELS = 2,
  parameter int unsigned COARSE_W = 9,
  parameter int unsigned PWM_W    = 3,
  parameter int unsigned TRIM_W   = 6,
  localparam int unsigned DATA_W  = COARSE_W + PWM_W + TRIM_W
) (
  input logic                         clk,
  input logic                         rst,
  input logic [CHANNELS*DATA_W-1:0]   sample_i,
  input logic [CHANNELS*COARSE_W-1:0] tap_o,
  input logic [CHANNELS-1:0]          pwm_hi_o,
  input logic [CHANNELS*TRIM_W-1:0]   trim_top_o,
  input logic [CHANNELS*TRIM_W-1:0]   trim_bot_o,
  input logic                         frame_o
);
  localparam logic [COARSE_W-1:0] MID_TAP  = {1'b1, {(COARSE_W-1){1'b0}}};
  localparam logic [TRIM_W-1:0]   TRIM_MAX = {TRIM_W{1'b1}};

  AST_FRAME_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frame_o |=> !frame_o); // R8

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chk
    AST_TRIM_SUM: assert property (@(posedge clk) disable iff (rst)
      (trim_top_o[c*TRIM_W +: TRIM_W] + trim_bot_o[c*TRIM_W +: TRIM_W]) == TRIM_W'(TRIM_MAX)); // R5

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !frame_o |-> ($stable(tap_o[c*COARSE_W +: COARSE_W]) &&
                    $stable(trim_bot_o[c*TRIM_W +: TRIM_W]))); // R6

    AST_PWM_NO_LATE_RISE: assert property (@(posedge clk) disable iff (rst)
      !frame_o |-> !$rose(pwm_hi_o[c])); // R3

    AST_TAP_FROM_SAMPLE: assert property (@(posedge clk) disable iff (rst)
      (frame_o && !$past(rst)) |->
        tap_o[c*COARSE_W +: COARSE_W] ==
        {~$past(sample_i[c*DATA_W + DATA_W-1]),
         $past(sample_i[c*DATA_W + DATA_W-2 -: COARSE_W-1])}); // R2

    AST_RESET_MID: assert property (@(posedge clk)
      rst |=> (tap_o[c*COARSE_W +: COARSE_W] == MID_TAP &&
               trim_top_o[c*TRIM_W +: TRIM_W] == TRIM_MAX &&
               !pwm_hi_o[c] && frame_o)); // R7
  end
endmodule

bind sds_sequencer sds_checker #(
  .CHANNELS (CHANNELS),
  .COARSE_W (COARSE_W),
  .PWM_W    (PWM_W),
  .TRIM_W   (TRIM_W)
) u_sds_checker (
  .clk        (clk),
  .rst        (rst),
  .sample_i   (sample_i),
  .tap_o      (tap_o),
  .pwm_hi_o   (pwm_hi_o),
  .trim_top_o (trim_top_o),
  .trim_bot_o (trim_bot_o),
  .frame_o    (frame_o)
);

// File: tb/tb_sds_sequencer.sv
`timescale 1ns/1ps
module tb_sds_sequencer;
  localparam int CH = 2;
  localparam int CW = 9;
  localparam int PW = 3;
  localparam int TW = 6;
  localparam int DW = CW + PW + TW;
  localparam int SLOTS = 1 << PW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CH*DW-1:0] sample_i = '0;
  logic [CH*CW-1:0] tap_o;
  logic [CH-1:0]    pwm_hi_o;
  logic [CH*TW-1:0] trim_top_o;
  logic [CH*TW-1:0] trim_bot_o;
  logic             frame_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [DW-1:0] shown [CH];

  always #2 clk = ~clk;

  sds_sequencer dut (
    .clk(clk), .rst(rst), .sample_i(sample_i), .tap_o(tap_o),
    .pwm_hi_o(pwm_hi_o), .trim_top_o(trim_top_o), .trim_bot_o(trim_bot_o),
    .frame_o(frame_o)
  );

  function automatic logic [DW-1:0] to_off(input logic [DW-1:0] s);
    return s ^ (1 << (DW-1));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_slot(input int s);
    chk(frame_o == (s == 0), "R8 frame", int'(frame_o), int'(s == 0));
    for (int c = 0; c < CH; c++) begin
      int t, p, b;
      t = int'(shown[c][DW-1 -: CW]);
      p = int'(shown[c][TW +: PW]);
      b = int'(shown[c][TW-1:0]);
      chk(int'(tap_o[c*CW +: CW]) == t, "R2 tap", int'(tap_o[c*CW +: CW]), t);
      chk(int'(pwm_hi_o[c]) == int'(s < p), "R3 pwm", int'(pwm_hi_o[c]), int'(s < p));
      chk(int'(trim_bot_o[c*TW +: TW]) == b, "R4 bottom trim", int'(trim_bot_o[c*TW +: TW]), b);
      chk(int'(trim_top_o[c*TW +: TW]) == 63 - b, "R5 top trim", int'(trim_top_o[c*TW +: TW]), 63 - b);
    end
  endtask

  // Called at a negedge in slot 0; plays out the frame while presenting the next samples.
  task automatic run_frame(input logic [DW-1:0] s0, input logic [DW-1:0] s1, input bit glitch);
    logic [CH*DW-1:0] nxt;
    nxt = {s1, s0};
    sample_i = nxt;
    for (int s = 0; s < SLOTS; s++) begin
      check_slot(s);
      if (glitch && s == 2) sample_i = {$urandom(), $urandom()}; // R6 mid-frame change
      if (glitch && s == 6) sample_i = nxt;
      @(negedge clk);
    end
    shown[0] = to_off(s0);
    shown[1] = to_off(s1);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not finish)");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0A1B));
    repeat (3) @(negedge clk);
    sample_i = {$urandom(), $urandom()}; // ignored during reset
    @(negedge clk);
    rst = 1'b0;
    // R7: reset state shown in slot 0 of the first frame
    shown[0] = 18'h20000;
    shown[1] = 18'h20000;
    chk(int'(tap_o[CW-1:0]) == 'h100, "R7 reset tap", int'(tap_o[CW-1:0]), 'h100);
    chk(int'(trim_top_o[TW-1:0]) == 63, "R7 reset top trim", int'(trim_top_o[TW-1:0]), 63);
    chk(frame_o == 1'b1, "R7 reset slot", int'(frame_o), 1);
    // R1 corner codes, R9 different per channel
    run_frame(18'h00000, 18'h1FFFF, 1'b0);
    chk(shown[0] == 18'h20000, "R1 zero", int'(shown[0]), 'h20000);
    run_frame(18'h20000, 18'h3FFFF, 1'b0);
    run_frame(18'h1FFFF, 18'h00000, 1'b1);
    run_frame(18'h3FFFF, 18'h20000, 1'b1);
    // R3 each switch code 0..7, R9 channels swap order
    for (int p = 0; p < SLOTS; p++) begin
      run_frame(18'(p << TW) | 18'h0002A, 18'((7 - p) << TW) | 18'h20015, 1'b0);
    end
    // random samples with mid-frame changes (R6)
    for (int i = 0; i < 60; i++) begin
      run_frame(18'($urandom()), 18'($urandom()), (i % 2) == 0);
    end
    run_frame(18'h0, 18'h0, 1'b0);
    check_slot(0);
    // R7 reset in mid-frame returns to midscale
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    shown[0] = 18'h20000;
    shown[1] = 18'h20000;
    check_slot(0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule